// File: doc/BRIEF.md
# Framebuffer control registers with vertical-sync interrupt

This block is the small register file that sits beside a framebuffer scan-out engine. A host reaches it over a byte-wide register bus with a 5-bit offset. It holds an interrupt-enable control byte, a status byte, and fourteen general bytes that the scan-out side uses for cursor start, cursor end and video control. The lower half of the offset space is not decoded. In that range reads give zero and writes are dropped.

The scan-out engine pulses `vsync` for one clock at each vertical sync. When interrupts are enabled, that pulse latches a pending flag, and the flag drives the level interrupt `irq`. The host acknowledges the interrupt by writing the status byte. The data written does not matter. A status read always merges in fixed monitor-sense and colour-board bits, so software can identify the board.

Read data is combinational from the offset. Writes take effect at the rising clock edge on which `wr_en` is sampled high.

Top module: `fb_ctrl_regs`

## Requirements
- R1: While `rst_n` is low and after its release, the control byte, the pending flag and all general bytes are zero, and `irq` is low.
- R2: Offset 0x10 is the control byte. All eight bits are written by a write and returned by a read. Bit 7 is the interrupt enable.
- R3: A cycle with `vsync` high while control bit 7 holds 1 (the value held before that edge) sets the pending flag at that edge. `irq` equals the pending flag.
- R4: A `vsync` pulse while control bit 7 is 0 leaves the pending flag unchanged.
- R5: A write to offset 0x11 clears the pending flag at that edge, whatever the write data is.
- R6: When a write to 0x11 and an enabled `vsync` fall in the same cycle, the pending flag is set after that edge.
- R7: A read of 0x11 returns the pending flag in bit 7, 1 in bits 6, 5 and 0, and 0 in bits 4 to 1, which gives 0x61 or 0xE1. No write changes bits 6 to 0.
- R8: Offsets 0x12 to 0x1F are independent read/write bytes.
- R9: Offsets 0x00 to 0x0F read as zero. Writes to them change no other register.
- R10: Once set, the pending flag stays set until a status write that is not met by an enabled `vsync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| vsync | input | 1 | One-cycle vertical-sync strobe |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The bench builds the block with its default parameters: a 5-bit offset, an 8-bit data path, the 0x61 status constant and bit 7 for both the enable and the pending flag. Under these values every one of the 32 offsets can be hit by random traffic, including the undecoded lower half. Vsync pulses are random and are often enabled. Status writes are frequent enough that the same-cycle collision between a vsync and an acknowledge occurs many times, in addition to a directed case for it.

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs #(
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int IRQ_BIT   = 7,
  parameter logic [DW-1:0] STAT_FIXED = 8'h61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          vsync,
  output logic          irq
);
  localparam int NREG  = 1 << (AW - 1);
  localparam int CTRL  = 0;
  localparam int STAT  = 1;
  localparam int GEN0  = 2;

  logic          in_win;
  logic [AW-2:0] idx;
  logic [DW-1:0] ctrl_q;
  logic          pend_q;
  logic [DW-1:0] gen_q [GEN0:NREG-1];
  logic          stat_wr, vs_hit;

  assign in_win  = addr[AW-1];
  assign idx     = addr[AW-2:0];
  assign stat_wr = wr_en && in_win && (idx == STAT[AW-2:0]);
  assign vs_hit  = vsync && ctrl_q[IRQ_BIT];
  assign irq     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && in_win && idx == CTRL[AW-2:0]) ctrl_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (vs_hit) pend_q <= 1'b1;
    else if (stat_wr) pend_q <= 1'b0;
  end

  for (genvar g = GEN0; g < NREG; g++) begin : g_gen
    always_ff @(posedge clk) begin
      if (!rst_n) gen_q[g] <= '0;
      else if (wr_en && in_win && idx == g[AW-2:0]) gen_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_win) begin
      if (idx == CTRL[AW-2:0])      rdata = ctrl_q;
      else if (idx == STAT[AW-2:0]) rdata = STAT_FIXED | (DW'(pend_q) << IRQ_BIT);
      else                          rdata = gen_q[idx];
    end
  end

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && ctrl_q[IRQ_BIT]) |=> irq);
  assert_noset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(vsync && ctrl_q[IRQ_BIT])) |=> !irq);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(NREG + STAT) && !(vsync && ctrl_q[IRQ_BIT])) |=> !irq);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == AW'(NREG + STAT))) |=> irq);
  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(NREG + STAT)) |-> (rdata == (STAT_FIXED | (DW'(irq) << IRQ_BIT))));
  assert_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[AW-1] |-> (rdata == '0));
endmodule

// File: tb/fb_ctrl_regs_test.sv
module fb_ctrl_regs_test;
  logic       clk = 0, rst_n = 0, wr_en = 0, vsync = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq;
  int checks = 0, errors = 0;

  logic [7:0] m_ctrl;
  logic       m_pend;
  logic [7:0] m_gen [2:15];

  always #2 clk = ~clk;

  fb_ctrl_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vsync(vsync), .irq(irq));

  function automatic logic [7:0] exp_read(logic [4:0] a);
    if (!a[4]) return 8'h00;
    if (a[3:0] == 0) return m_ctrl;
    if (a[3:0] == 1) return {m_pend, 7'h61};
    return m_gen[a[3:0]];
  endfunction

  function automatic string req_of(logic [4:0] a);
    if (!a[4]) return "R9";
    if (a[3:0] == 0) return "R2";
    if (a[3:0] == 1) return "R7";
    return "R8";
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 0; m_pend = 0;
    for (int i = 2; i < 16; i++) m_gen[i] = 0;
  endtask

  task automatic step(logic w, logic [4:0] a, logic [7:0] d, logic vs, string irq_req);
    logic np;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; vsync = vs;
    #1;
    chk(req_of(a), rdata, exp_read(a));
    chk(irq_req, {7'h0, irq}, {7'h0, m_pend});
    @(posedge clk);
    np = (vs && m_ctrl[7]) || (m_pend && !(w && a == 5'h11));
    if (w && a == 5'h10) m_ctrl = d;
    if (w && a[4] && a[3:1] != 0) m_gen[a[3:0]] = d;
    m_pend = np;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {7'h0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    // R1: all registers zero after reset
    for (int a = 16; a < 32; a++) step(0, 5'(a), 8'h00, 0, "R1");
    // R4: vsync with enable clear
    step(1, 5'h10, 8'h7F, 0, "R2");
    step(0, 5'h11, 0, 1, "R4");
    step(0, 5'h11, 0, 0, "R4");
    // R3: enabled vsync sets pending
    step(1, 5'h10, 8'h80, 0, "R2");
    step(0, 5'h11, 0, 1, "R3");
    step(0, 5'h11, 0, 0, "R3");
    // R10: pending holds
    repeat (3) step(1, 5'h12, 8'h5A, 0, "R10");
    // R7: bits below 7 not writable; R5: any data clears
    step(1, 5'h11, 8'h1E, 0, "R5");
    step(0, 5'h11, 0, 0, "R5");
    step(0, 5'h11, 0, 1, "R3");
    // R6: collision keeps pending
    step(1, 5'h11, 8'hFF, 1, "R6");
    step(0, 5'h11, 0, 0, "R6");
    step(1, 5'h11, 8'h00, 0, "R5");
    // R9: low writes have no effect
    for (int a = 0; a < 16; a++) step(1, 5'(a), 8'hFF, 0, "R9");
    for (int a = 0; a < 32; a++) step(0, 5'(a), 0, 0, "R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] a;
      logic w, vs;
      a  = ($urandom % 4 == 0) ? 5'h11 : 5'($urandom);
      w  = ($urandom % 2) == 1;
      vs = ($urandom % 5) == 0;
      step(w, a, 8'($urandom), vs, "R3");
    end
    for (int a = 0; a < 32; a++) step(0, 5'(a), 0, 0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule